// File: doc/BRIEF.md
# Extended-Range Data Read Timeout Timer

This block watches a data read on a card bus and flags a timeout when no data shows up within a programmed number of card-clock cycles. The timeout comes from a 32-bit configuration word. The low byte is a response timeout, which the block only stores and passes on. The upper 24 bits hold a data timeout in a compact extended form: a 3-bit multiplier of 0xFFFFFF cycles plus a 21-bit fine count in units of 8 cycles. This reaches up to 0x6FFFFF2 card-clock cycles.

The card clock is derived from the bus clock by a divider. The low byte of the divider word gives a field D. One card clock lasts 2·D bus clocks, and D = 0 means the clock is not divided. When a read starts, the timer loads the decoded count. It then counts down once per card-clock period and stops when data arrives. If it runs out, it sets a sticky flag that software clears. The decoded count is also presented on an output so that software can read back how long the programmed timeout is.

Top module: `xrt_read_timer`

## Requirements
- R1: `rsp_tmo_o` always equals bits [7:0] of `tmo_reg_i`.
- R2: With M = `tmo_reg_i`[10:8] and F = `tmo_reg_i`[31:11], and M ≥ 1, `data_tmo_cycles_o` equals (M − 1) × 0xFFFFFF + F × 8.
- R3: When M = 0, `data_tmo_cycles_o` is 0 rather than a wrapped value.
- R4: All ones in bits [31:8] decode to 0x6FFFFF2, and no encoding decodes to more.
- R5: The countdown advances once every P bus clocks, where P = 2·D and D = `clkdiv_reg_i`[7:0]. D = 0 gives P = 1. Bits [31:8] of `clkdiv_reg_i` have no effect.
- R6: A start pulse sampled at edge E with a decoded count N ≥ 1 and no arriving data sets `data_tmo_flag_o` at edge E + N·P and not before.
- R7: `data_seen_i` sampled while counting stops the countdown. The flag then stays low.
- R8: A start with a decoded count of 0 sets the flag at the same edge that samples the start.
- R9: Once set, the flag stays set until `flag_clr_i` is sampled. After that it reads 0.
- R10: `busy_o` is high from the edge after a start with N ≥ 1 until the countdown expires or data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_reg_i | input | 32 | Timeout configuration word |
| clkdiv_reg_i | input | 32 | Divider word; only bits [7:0] are used |
| rd_start_i | input | 1 | One-cycle pulse: a data read begins |
| data_seen_i | input | 1 | Pulse: read data has arrived |
| flag_clr_i | input | 1 | Pulse: clear the timeout flag |
| rsp_tmo_o | output | 8 | Stored response timeout |
| data_tmo_cycles_o | output | 27 | Decoded data timeout in card-clock cycles |
| busy_o | output | 1 | Countdown running |
| data_tmo_flag_o | output | 1 | Sticky data-read timeout flag |

## Verification
The two decode outputs are combinational, so the bench checks them one step after it changes the configuration word. The flag is due exactly N·P edges after the edge that samples the start pulse, or at that same edge when N is 0. To check this, the bench advances one bus clock at a time, 1 ns after each rising edge. It confirms that the flag is low on each of the first N·P − 1 steps and high on step N·P. Clearing and data arrival are checked on the step that follows the edge that samples them.

// File: rtl/xrt_pkg.sv
package xrt_pkg;

   // Largest cycle count the extended encoding can express.
   function automatic longint span_max(int mult_w, int fine_w, int fine_sh, longint unit);
      longint top_mult;
      longint top_fine;
      top_mult = (longint'(1) << mult_w) - 2;
      top_fine = ((longint'(1) << fine_w) - 1) << fine_sh;
      return top_mult * unit + top_fine;
   endfunction

   // Bits needed to hold span_max.
   function automatic int span_width(int mult_w, int fine_w, int fine_sh, longint unit);
      return $clog2(span_max(mult_w, fine_w, fine_sh, unit) + 1);
   endfunction

endpackage

// File: rtl/xrt_span_decode.sv
module xrt_span_decode #(
   parameter int          MULT_W   = 3,
   parameter int          FINE_W   = 21,
   parameter int          FINE_SH  = 3,
   parameter int unsigned UNIT     = 32'h00FF_FFFF,
   parameter bit          SAT_ZERO = 1'b1,
   parameter int          CNT_W    = 27
) (
   input  logic [MULT_W-1:0] mult_i,
   input  logic [FINE_W-1:0] fine_i,
   output logic [CNT_W-1:0]  cycles_o
);

   initial begin
      if (FINE_W + FINE_SH > CNT_W) $error("fine field does not fit the count");
      if (MULT_W < 1) $error("multiplier field must be at least one bit");
   end

   logic [CNT_W-1:0] mult_ext;
   logic [CNT_W-1:0] coarse;
   logic [CNT_W-1:0] fine_sc;
   logic [CNT_W-1:0] raw_sum;

   always_comb begin
      mult_ext = CNT_W'(mult_i);
      coarse   = (mult_ext - CNT_W'(1)) * CNT_W'(UNIT);
      fine_sc  = CNT_W'(fine_i) << FINE_SH;
      raw_sum  = coarse + fine_sc;
   end

   generate
      if (SAT_ZERO) begin : g_sat
         assign cycles_o = (mult_i == '0) ? '0 : raw_sum;
      end else begin : g_wrap
         assign cycles_o = raw_sum;
      end
   endgenerate

endmodule

// File: rtl/xrt_cclk_tick.sv
module xrt_cclk_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   input  logic             run_i,
   input  logic             restart_i,
   output logic             tick_o
);

   localparam int PC_W = DIV_W + 1;

   initial begin
      if (DIV_W < 1) $error("divider width must be positive");
   end

   logic [PC_W-1:0] phase_q;
   logic [PC_W-1:0] last_phase;

   assign last_phase = {div_i, 1'b0} - PC_W'(1);
   assign tick_o     = run_i && !restart_i && ((div_i == '0) || (phase_q == last_phase));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart_i || !run_i || tick_o) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + PC_W'(1);
      end
   end

   // R5: an undivided clock ticks on every running cycle
   assert_undivided_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !restart_i && div_i == '0) |-> tick_o);

   // R5: with a divider in force, ticks never come on adjacent cycles
   assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && div_i != '0) ##1 (div_i != '0 && $stable(div_i)) |-> !tick_o);

endmodule

// File: rtl/xrt_countdown.sv
module xrt_countdown #(
   parameter int CNT_W = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             tick_i,
   input  logic             arrive_i,
   input  logic             clr_i,
   output logic             active_o,
   output logic             flag_o
);

   logic [CNT_W-1:0] remain_q;
   logic             active_q;
   logic             flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         active_q <= 1'b0;
         flag_q   <= 1'b0;
      end else begin
         if (clr_i) flag_q <= 1'b0;
         if (load_i) begin
            if (load_val_i == '0) begin
               active_q <= 1'b0;
               flag_q   <= 1'b1;
               remain_q <= '0;
            end else begin
               active_q <= 1'b1;
               remain_q <= load_val_i;
            end
         end else if (active_q) begin
            if (arrive_i) begin
               active_q <= 1'b0;
            end else if (tick_i) begin
               if (remain_q == CNT_W'(1)) begin
                  active_q <= 1'b0;
                  flag_q   <= 1'b1;
                  remain_q <= '0;
               end else begin
                  remain_q <= remain_q - CNT_W'(1);
               end
            end
         end
      end
   end

   assign active_o = active_q;
   assign flag_o   = flag_q;

   // R9: the flag holds until a clear is seen
   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);

   // R7: arriving data ends the countdown
   assert_arrival_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && arrive_i && !load_i) |=> (!active_q && $stable(flag_q)));

   // R6: a running countdown never reaches zero while still active
   assert_live_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (remain_q != '0));

endmodule

// File: rtl/xrt_read_timer.sv
module xrt_read_timer #(
   parameter int          REG_W    = 32,
   parameter int          RSP_W    = 8,
   parameter int          MULT_W   = 3,
   parameter int          FINE_W   = 21,
   parameter int          FINE_SH  = 3,
   parameter int unsigned UNIT     = 32'h00FF_FFFF,
   parameter int          DIV_W    = 8,
   parameter bit          SAT_ZERO = 1'b1,
   localparam int         CNT_W    = xrt_pkg::span_width(MULT_W, FINE_W, FINE_SH, longint'(UNIT))
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] tmo_reg_i,
   input  logic [REG_W-1:0] clkdiv_reg_i,
   input  logic             rd_start_i,
   input  logic             data_seen_i,
   input  logic             flag_clr_i,
   output logic [RSP_W-1:0] rsp_tmo_o,
   output logic [CNT_W-1:0] data_tmo_cycles_o,
   output logic             busy_o,
   output logic             data_tmo_flag_o
);

   localparam int     MULT_LO  = RSP_W;
   localparam int     FINE_LO  = RSP_W + MULT_W;
   localparam longint SPAN_TOP = xrt_pkg::span_max(MULT_W, FINE_W, FINE_SH, longint'(UNIT));

   initial begin
      if (REG_W != RSP_W + MULT_W + FINE_W) $error("register fields do not fill the word");
      if (DIV_W > REG_W) $error("divider field wider than its register");
   end

   logic [MULT_W-1:0] mult_f;
   logic [FINE_W-1:0] fine_f;
   logic [DIV_W-1:0]  div_f;
   logic [CNT_W-1:0]  span;
   logic              tick;
   logic              active;

   assign rsp_tmo_o = tmo_reg_i[RSP_W-1:0];
   assign mult_f    = tmo_reg_i[FINE_LO-1:MULT_LO];
   assign fine_f    = tmo_reg_i[REG_W-1:FINE_LO];
   assign div_f     = clkdiv_reg_i[DIV_W-1:0];

   xrt_span_decode #(
      .MULT_W(MULT_W), .FINE_W(FINE_W), .FINE_SH(FINE_SH),
      .UNIT(UNIT), .SAT_ZERO(SAT_ZERO), .CNT_W(CNT_W)
   ) decode_i (
      .mult_i  (mult_f),
      .fine_i  (fine_f),
      .cycles_o(span)
   );

   xrt_cclk_tick #(.DIV_W(DIV_W)) tick_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_i    (div_f),
      .run_i    (active),
      .restart_i(rd_start_i),
      .tick_o   (tick)
   );

   xrt_countdown #(.CNT_W(CNT_W)) count_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (rd_start_i),
      .load_val_i(span),
      .tick_i    (tick),
      .arrive_i  (data_seen_i),
      .clr_i     (flag_clr_i),
      .active_o  (active),
      .flag_o    (data_tmo_flag_o)
   );

   assign data_tmo_cycles_o = span;
   assign busy_o            = active;

   // R3: a zero multiplier saturates the decode
   assert_zero_mult_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!SAT_ZERO || mult_f != '0 || data_tmo_cycles_o == '0));

   // R4: nothing decodes past the top of the range
   assert_span_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (longint'(data_tmo_cycles_o) <= SPAN_TOP));

   // R8: a zero-length timeout fires at once
   assert_zero_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start_i && data_tmo_cycles_o == '0) |=> (data_tmo_flag_o && !busy_o));

   // R10: a non-zero start makes the timer busy
   assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start_i && data_tmo_cycles_o != '0) |=> busy_o);

endmodule

// File: tb/xrt_read_timer_tb_top.sv
module xrt_read_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] tmo_reg_i = 32'h0;
   logic [31:0] clkdiv_reg_i = 32'h0;
   logic        rd_start_i = 1'b0;
   logic        data_seen_i = 1'b0;
   logic        flag_clr_i = 1'b0;
   logic [7:0]  rsp_tmo_o;
   logic [26:0] data_tmo_cycles_o;
   logic        busy_o;
   logic        data_tmo_flag_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   xrt_read_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tmo_reg_i(tmo_reg_i), .clkdiv_reg_i(clkdiv_reg_i),
      .rd_start_i(rd_start_i), .data_seen_i(data_seen_i), .flag_clr_i(flag_clr_i),
      .rsp_tmo_o(rsp_tmo_o), .data_tmo_cycles_o(data_tmo_cycles_o),
      .busy_o(busy_o), .data_tmo_flag_o(data_tmo_flag_o)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic longint model_span(input logic [31:0] w);
      longint m = longint'(w[10:8]);
      longint f = longint'(w[31:11]);
      if (m == 0) return 0;
      return (m - 1) * 64'hFF_FFFF + f * 8;
   endfunction

   function automatic logic [31:0] enc(input int m, input int f, input int rsp);
      return {f[20:0], m[2:0], rsp[7:0]};
   endfunction

   task automatic start_read();
      rd_start_i = 1'b1;
      step();
      rd_start_i = 1'b0;
   endtask

   task automatic t_reset();
      check("R9 reset flag", data_tmo_flag_o, 0);
      check("R10 reset busy", busy_o, 0);
   endtask

   task automatic t_decode();
      logic [31:0] vals [6];
      vals[0] = enc(1, 0, 8'hFF);
      vals[1] = enc(2, 0, 8'h12);
      vals[2] = enc(3, 5, 8'h00);
      vals[3] = enc(1, 2, 8'hA5);
      vals[4] = enc(6, 12345, 8'h3C);
      vals[5] = enc(4, 21'h1FFFFF, 8'h7E);
      foreach (vals[i]) begin
         tmo_reg_i = vals[i];
         step();
         check("R2 decode", data_tmo_cycles_o, model_span(vals[i]));
         check("R1 response field", rsp_tmo_o, vals[i][7:0]);
      end
      tmo_reg_i = enc(0, 21'h1ABCD, 8'hFF);
      step();
      check("R3 zero multiplier", data_tmo_cycles_o, 0);
      tmo_reg_i = 32'hFFFF_FFFF;
      step();
      check("R4 maximum", data_tmo_cycles_o, 64'h6FF_FFF2);
   endtask

   // Start a read and confirm the flag rises exactly n*p edges later.
   task automatic t_expire(input logic [31:0] w, input logic [31:0] dv, input int n, input int p,
                           input string req);
      int early = 0;
      tmo_reg_i = w;
      clkdiv_reg_i = dv;
      step();
      start_read();
      check("R10 busy after start", busy_o, 1);
      for (int i = 1; i < n * p; i++) begin
         step();
         if (data_tmo_flag_o) early++;
      end
      check({req, " no early flag"}, early, 0);
      step();
      check({req, " flag on time"}, data_tmo_flag_o, 1);
      check("R10 idle after expiry", busy_o, 0);
   endtask

   task automatic t_sticky_clear();
      for (int i = 0; i < 6; i++) step();
      check("R9 flag held", data_tmo_flag_o, 1);
      flag_clr_i = 1'b1;
      step();
      flag_clr_i = 1'b0;
      check("R9 flag cleared", data_tmo_flag_o, 0);
   endtask

   task automatic t_arrival();
      int seen = 0;
      tmo_reg_i = enc(1, 2, 8'hFF);
      clkdiv_reg_i = 32'h0;
      step();
      start_read();
      for (int i = 0; i < 5; i++) step();
      data_seen_i = 1'b1;
      step();
      data_seen_i = 1'b0;
      check("R7 busy drops on data", busy_o, 0);
      for (int i = 0; i < 40; i++) begin
         step();
         if (data_tmo_flag_o) seen++;
      end
      check("R7 no timeout after data", seen, 0);
   endtask

   task automatic t_zero();
      tmo_reg_i = enc(0, 7, 8'hFF);
      step();
      start_read();
      check("R8 immediate flag", data_tmo_flag_o, 1);
      check("R8 not busy", busy_o, 0);
      flag_clr_i = 1'b1;
      step();
      flag_clr_i = 1'b0;
   endtask

   initial begin
      #1;
      step();
      step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_decode();
      t_expire(enc(1, 2, 8'hFF), 32'h0, 16, 1, "R6 undivided");
      t_sticky_clear();
      t_expire(enc(1, 1, 8'hFF), 32'hAB00_0002, 8, 4, "R5 divided by four");
      t_sticky_clear();
      t_expire(enc(1, 1, 8'hFF), 32'h0000_0003, 8, 6, "R5 divided by six");
      t_sticky_clear();
      t_arrival();
      t_zero();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule